// File: doc/BRIEF.md
# Key-Sequence Write Protection Gate

This block sits in front of a group of configuration registers that must not be changed by a stray bus write: the time and date counters, the control word, the clock prescaler and the alarm setting. It watches writes to a dedicated key port. Software opens the gate by writing two fixed key bytes to that port, one after the other. While the gate is open, write requests aimed at the guarded registers pass through as write enables. While it is closed, they are blocked.

Writing any value to the key port other than the next expected key closes the gate at once. Software normally writes a known bad byte, such as 0xFF, when it has finished its update. The guarded registers are outside this block. Each register takes its write enable from the matching bit of the qualifier output.

Top module: `wprot_gate`

## Requirements
- R1: While reset is active, and right after it is released, `unlocked` is 0 and every bit of `tgt_we` is 0, whatever `tgt_req` carries.
- R2: A key write of 0xCA followed by a key write of 0x53 opens the gate. `unlocked` rises in the cycle after the 0x53 write. Cycles without a key write may fall between the two key writes.
- R3: A key write of 0x53 from the locked idle state does not open the gate.
- R4: After 0xCA, a key write of any value other than 0x53, including 0xCA again, returns the gate to idle. A following 0x53 then does not open it.
- R5: While the gate is open, any key write closes it, and `unlocked` is 0 in the next cycle. This includes a repeat of 0x53.
- R6: A key write of 0xCA while the gate is open counts as a new first key, so a following 0x53 opens the gate again.
- R7: While locked, `tgt_we` is all zero and guarded writes are ignored. While open, `tgt_we` equals `tgt_req` in the same cycle. The bits are assigned as follows: bit 0 time, bit 1 date, bit 2 control, bit 3 prescaler, bit 4 alarm.
- R8: Requests on `tgt_req` never change the lock state. Only key writes change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Write strobe for the key port |
| key_byte | input | 8 | Data written to the key port |
| tgt_req | input | 5 | Write requests to the guarded registers, one bit per register |
| tgt_we | output | 5 | Write enables passed on to the guarded registers |
| unlocked | output | 1 | High while the gate is open |

## Verification
The assertions check the following on every cycle:
- a closed gate never passes a write enable;
- an open gate passes exactly the requested bits;
- the gate opens only in the cycle after a 0x53 key write;
- a bad key write always leaves the gate closed;
- the lock state never moves without a key write.

Only the bench scenarios can show that the two keys must arrive in order. They also show that 0xCA restarts the sequence from the open state, that a wrong second key must be followed by a full new sequence, and that guarded writes issued while locked have no effect.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ARMED = 2'd1,
    GS_OPEN  = 2'd2
  } gate_state_e;
endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wprot_key_match.sv
module wprot_key_match #(
  parameter int          KEY_W      = 8,
  parameter logic [7:0]  KEY_FIRST  = 8'hCA,
  parameter logic [7:0]  KEY_SECOND = 8'h53
) (
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  output logic             hit_first,
  output logic             hit_second
);
  localparam logic [KEY_W-1:0] K1 = KEY_W'(KEY_FIRST);
  localparam logic [KEY_W-1:0] K2 = KEY_W'(KEY_SECOND);

  always_comb begin
    hit_first  = key_wr && (key_byte == K1);
    hit_second = key_wr && (key_byte == K2);
  end
endmodule

// File: rtl/wprot_fsm.sv
module wprot_fsm
  import wprot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  logic hit_first,
  input  logic hit_second,
  output logic open_q
);
  gate_state_e state_q, state_d;
  logic        state_en;
  logic        open_d;

  always_comb begin
    state_d  = state_q;
    state_en = key_wr;
    unique case (state_q)
      GS_IDLE:  state_d = hit_first  ? GS_ARMED : GS_IDLE;
      GS_ARMED: state_d = hit_second ? GS_OPEN  : GS_IDLE;
      GS_OPEN:  state_d = hit_first  ? GS_ARMED : GS_IDLE;
      default:  state_d = GS_IDLE;
    endcase
    open_d = (state_d == GS_OPEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      open_q  <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
      open_q  <= open_d;
    end
  end
endmodule

// File: rtl/wprot_qual.sv
module wprot_qual #(
  parameter int N_TGT = 5
) (
  input  logic             open_q,
  input  logic [N_TGT-1:0] tgt_req,
  output logic [N_TGT-1:0] tgt_we
);
  for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
    assign tgt_we[i] = tgt_req[i] & open_q;
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int         KEY_W      = 8,
  parameter logic [7:0] KEY_FIRST  = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53,
  parameter int         N_TGT      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  input  logic [N_TGT-1:0] tgt_req,
  output logic [N_TGT-1:0] tgt_we,
  output logic             unlocked
);
  logic rst_n_s;
  logic hit_first, hit_second;
  logic open_q;

  wprot_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wprot_key_match #(
    .KEY_W      (KEY_W),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_match (
    .key_wr     (key_wr),
    .key_byte   (key_byte),
    .hit_first  (hit_first),
    .hit_second (hit_second)
  );

  wprot_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .key_wr     (key_wr),
    .hit_first  (hit_first),
    .hit_second (hit_second),
    .open_q     (open_q)
  );

  wprot_qual #(.N_TGT(N_TGT)) u_qual (
    .open_q  (open_q),
    .tgt_req (tgt_req),
    .tgt_we  (tgt_we)
  );

  assign unlocked = open_q;
endmodule

// File: rtl/wprot_gate_chk.sv
module wprot_gate_chk #(
  parameter int         KEY_W      = 8,
  parameter logic [7:0] KEY_FIRST  = 8'hCA,
  parameter logic [7:0] KEY_SECOND = 8'h53,
  parameter int         N_TGT      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             key_wr,
  input logic [KEY_W-1:0] key_byte,
  input logic [N_TGT-1:0] tgt_req,
  input logic [N_TGT-1:0] tgt_we,
  input logic             unlocked
);
  localparam logic [KEY_W-1:0] K1 = KEY_W'(KEY_FIRST);
  localparam logic [KEY_W-1:0] K2 = KEY_W'(KEY_SECOND);

  // R1: a held reset keeps the gate shut
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_locked: assert (!unlocked && tgt_we == '0);
  end

  // R2, R3: the gate opens only after a second-key write
  a_r2_open_after_second: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> ($past(key_wr) && $past(key_byte) == K2));

  // R4, R5: a bad key write leaves the gate shut
  a_r5_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_byte != K2) |=> !unlocked);

  // R7: a locked gate passes nothing
  a_r7_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (tgt_we == '0));

  // R7: an open gate passes exactly the requests
  a_r7_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> (tgt_we == tgt_req));

  // R8: only key writes move the lock state
  a_r8_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(unlocked));
endmodule

bind wprot_gate wprot_gate_chk #(
  .KEY_W      (KEY_W),
  .KEY_FIRST  (KEY_FIRST),
  .KEY_SECOND (KEY_SECOND),
  .N_TGT      (N_TGT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .key_wr   (key_wr),
  .key_byte (key_byte),
  .tgt_req  (tgt_req),
  .tgt_we   (tgt_we),
  .unlocked (unlocked)
);

// File: tb/wprot_gate_tb.sv
module wprot_gate_tb;
  logic       clk;
  logic       rst_n;
  logic       key_wr;
  logic [7:0] key_byte;
  logic [4:0] tgt_req;
  logic [4:0] tgt_we;
  logic       unlocked;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic       exp_open;
    logic [4:0] exp_we;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int        model_st = 0;  // 0 idle, 1 first key seen, 2 open

  wprot_gate u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (key_byte),
    .tgt_req  (tgt_req),
    .tgt_we   (tgt_we),
    .unlocked (unlocked)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected outputs pushed for this cycle
  task automatic step(input bit kw, input logic [7:0] kb, input logic [4:0] req,
                      input string tag, input bit score);
    exp_item_t it;
    @(negedge clk);
    key_wr   = kw;
    key_byte = kb;
    tgt_req  = req;
    if (score) begin
      it.exp_open = (model_st == 2);
      it.exp_we   = (model_st == 2) ? req : 5'b0;
      it.tag      = tag;
      sb_q.push_back(it);
    end
    if (kw) begin
      case (model_st)
        0:       model_st = (kb == 8'hCA) ? 1 : 0;
        1:       model_st = (kb == 8'h53) ? 2 : 0;
        default: model_st = (kb == 8'hCA) ? 1 : 0;
      endcase
    end
  endtask

  // monitor: compare outputs of the cycle just driven
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(it.tag, {unlocked, tgt_we}, {it.exp_open, it.exp_we});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; key_wr = 0; key_byte = 8'h00; tgt_req = 5'b11111;
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset", {unlocked, tgt_we}, 6'b0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after reset", {unlocked, tgt_we}, 6'b0);

    // R7: locked writes ignored
    step(0, 8'h00, 5'b10101, "R7 locked write", 1);
    // R3: second key alone
    step(1, 8'h53, 5'b0, "R3 key2 alone", 1);
    step(0, 8'h00, 5'b11111, "R3 still locked", 1);
    // R2: proper sequence with gap
    step(1, 8'hCA, 5'b0, "R2 key1", 1);
    step(0, 8'h00, 5'b00001, "R2 gap", 1);
    step(1, 8'h53, 5'b00010, "R2 key2", 1);
    step(0, 8'h00, 5'b11111, "R2 open all", 1);
    // R7 and R8: guarded writes pass, state unaffected
    step(0, 8'h00, 5'b00100, "R7 control", 1);
    step(0, 8'h00, 5'b01000, "R8 prescaler", 1);
    step(0, 8'h00, 5'b10000, "R8 alarm", 1);
    // R5: repeat of second key closes
    step(1, 8'h53, 5'b00001, "R5 key2 again", 1);
    step(0, 8'h00, 5'b11111, "R5 closed", 1);
    // R4: wrong second key, then bare key2
    step(1, 8'hCA, 5'b0, "R4 key1", 1);
    step(1, 8'h12, 5'b0, "R4 wrong", 1);
    step(1, 8'h53, 5'b0, "R4 late key2", 1);
    step(0, 8'h00, 5'b11111, "R4 locked", 1);
    // R4: key1 twice
    step(1, 8'hCA, 5'b0, "R4 key1 a", 1);
    step(1, 8'hCA, 5'b0, "R4 key1 b", 1);
    step(1, 8'h53, 5'b0, "R4 key2 after double", 1);
    step(0, 8'h00, 5'b11111, "R4 double locked", 1);
    // R6: key1 while open relocks and re-arms
    step(1, 8'hCA, 5'b0, "R6 k1", 1);
    step(1, 8'h53, 5'b0, "R6 k2", 1);
    step(0, 8'h00, 5'b01010, "R6 open", 1);
    step(1, 8'hCA, 5'b00011, "R6 key1 while open", 1);
    step(0, 8'h00, 5'b11111, "R6 relocked", 1);
    step(1, 8'h53, 5'b0, "R6 key2 reopen", 1);
    step(0, 8'h00, 5'b11111, "R6 reopened", 1);
    // R5: lock byte
    step(1, 8'hFF, 5'b11111, "R5 lock byte", 1);
    step(0, 8'h00, 5'b11111, "R5 locked after FF", 1);
    step(0, 8'h00, 5'b0, "R1 idle", 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule